// File: doc/BRIEF.md
# UART Banked Register Interface

This block is the byte-wide register front end of a 16550-class serial port. It has a small address space, and what an address means depends on the line control byte that software last wrote. There are three views. The normal view is the usual operating set. The divisor view exposes the two baud divisor bytes. The extended view is a hidden bank that holds the enhanced-feature register. A separate mode register keeps the serial engine disabled after reset until software clears it.

The view is held in a small state machine with three states: `VIEW_NORMAL`, `VIEW_DIVISOR` and `VIEW_EXTENDED`. The machine changes state only on a write to the line control offset, and it can move from any state to any other.

- Transition `GO_EXTENDED`: the written byte equals 0xBF.
- Transition `GO_DIVISOR`: bit 7 of the written byte is set and the byte is not 0xBF.
- Transition `GO_NORMAL`: bit 7 is clear.

A write to any other offset keeps the state (`STAY`).

The block drives these signals to the rest of the serial port:

- the 16-bit divisor;
- the decoded frame format;
- the FIFO enable level and the single-cycle FIFO clear strobes;
- the enhanced-functions flag;
- the operating mode.

The serial shifter, the baud generator and the FIFO storage are not part of this block. The interrupt identification byte comes in as an input and is only read back.

Top module: `uart_regbank`

## Requirements
- R1: After reset, the following values hold. Line control reads 0x00 and the divisor is 0x0000. The enhanced-feature register is 0x00, so `enh_en` is 0. The mode register reads 0x07, so `op_mode` is 7 and `uart_enable` is 0. `fifo_en` and both clear strobes are 0. The frame format is 5 data bits, one stop bit and no parity.
- R2: Offset 3 is the line control register in every view. A write stores all 8 bits, and a read returns the stored byte.
- R3: When line control bit 7 is 1 (divisor or extended view), offset 0 reads and writes the divisor low byte and offset 1 the high byte. `divisor` presents {high, low} from the cycle after the write. For example, 42 then 0 gives 0x002A.
- R4: When line control equals 0xBF, offset 2 reads and writes the enhanced-feature register, and `enh_en` equals bit 4 of that register.
- R5: A write to offset 2 while line control is not 0xBF never changes the enhanced-feature register.
- R6: When line control is not 0xBF, a write to offset 2 goes to FIFO control, and a read from offset 2 returns `iir_in`. In the normal view (bit 7 = 0), offsets 0 and 1 read 0x00, and writes to them leave the divisor unchanged.
- R7: FIFO control works bit by bit. Bit 0 sets the `fifo_en` level. Bit 1 pulses `rx_fifo_clr` and bit 2 pulses `tx_fifo_clr`, each high for exactly the one cycle after the write. FIFO control is never read back.
- R8: Every line control write other than 0xBF updates the format outputs:
  - bits 1:0 give `data_bits` = 5 + value (5 to 8);
  - bit 2 gives `stop_two`;
  - bit 3 gives `parity_en`.
- R9: Writing 0xBF to line control leaves `data_bits`, `stop_two` and `parity_en` unchanged.
- R10: Offset 8 is the 3-bit mode register and reads back in bits 2:0. `op_mode` shows its value. `uart_enable` is 1 only when the mode is 0; value 7 holds the UART in reset.
- R11: Offsets 4 to 7 and 9 to 15 read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 4 | Register offset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| iir_in | input | 8 | Interrupt identification byte from the UART core |
| divisor | output | 16 | Baud divisor {high, low} |
| data_bits | output | 4 | Data bits per character, 5 to 8 |
| stop_two | output | 1 | Two stop bits selected |
| parity_en | output | 1 | Parity enabled |
| fifo_en | output | 1 | FIFOs enabled |
| rx_fifo_clr | output | 1 | One-cycle receive FIFO clear strobe |
| tx_fifo_clr | output | 1 | One-cycle transmit FIFO clear strobe |
| enh_en | output | 1 | Enhanced functions enabled |
| op_mode | output | 3 | Operating mode value |
| uart_enable | output | 1 | High when the mode is plain UART (0) |

## Verification
A view state that disagrees with the stored line control byte shows up on the very next access to offsets 0 to 2. The read returns the wrong register, or the write lands in the wrong one. For example, a write meant for the FIFO control register would change `enh_en` in the following cycle. A corrupted format shadow appears on the format outputs one cycle after a 0xBF write, even though those outputs should hold. A clear strobe that is held as state instead of pulsing stays high for a second cycle, so it is caught one cycle after the write.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

    typedef enum logic [1:0] {
        VIEW_NORMAL   = 2'd0,
        VIEW_DIVISOR  = 2'd1,
        VIEW_EXTENDED = 2'd2
    } view_e;

    typedef struct packed {
        logic       parity_en;
        logic       stop_two;
        logic [1:0] wlen;
    } frame_t;

    localparam logic [7:0] LCR_EXT_KEY = 8'hBF;

endpackage

// File: rtl/uart_view_fsm.sv
module uart_view_fsm
    import uart_regbank_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BANK_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lcr_wr,
    input  logic [DATA_W-1:0] wdata,
    output view_e             view,
    output logic              sel_div,
    output logic              sel_ext
);

    view_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= VIEW_NORMAL;
        else        state_q <= state_d;
    end

    // Transitions: GO_EXTENDED, GO_DIVISOR, GO_NORMAL, STAY
    always_comb begin
        state_d = state_q;
        if (lcr_wr) begin
            if (wdata == DATA_W'(LCR_EXT_KEY)) state_d = VIEW_EXTENDED;
            else if (wdata[BANK_BIT])          state_d = VIEW_DIVISOR;
            else                               state_d = VIEW_NORMAL;
        end
    end

    // Outputs
    always_comb begin
        view    = state_q;
        sel_div = 1'b0;
        sel_ext = 1'b0;
        unique case (state_q)
            VIEW_NORMAL:   begin sel_div = 1'b0; sel_ext = 1'b0; end
            VIEW_DIVISOR:  begin sel_div = 1'b1; sel_ext = 1'b0; end
            VIEW_EXTENDED: begin sel_div = 1'b1; sel_ext = 1'b1; end
            default:       begin sel_div = 1'b0; sel_ext = 1'b0; end
        endcase
    end

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl #(
    parameter int DATA_W    = 8,
    parameter int EN_BIT    = 0,
    parameter int RXCLR_BIT = 1,
    parameter int TXCLR_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fcr_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              fifo_en,
    output logic              rx_clr,
    output logic              tx_clr
);

    logic en_q, rx_q, tx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            rx_q <= 1'b0;
            tx_q <= 1'b0;
        end else begin
            rx_q <= fcr_wr & wdata[RXCLR_BIT];
            tx_q <= fcr_wr & wdata[TXCLR_BIT];
            if (fcr_wr) en_q <= wdata[EN_BIT];
        end
    end

    assign fifo_en = en_q;
    assign rx_clr  = rx_q;
    assign tx_clr  = tx_q;

endmodule

// File: rtl/uart_fmt_decode.sv
module uart_fmt_decode
    import uart_regbank_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int MIN_BITS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lcr_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [3:0]        data_bits,
    output logic              stop_two,
    output logic              parity_en
);

    frame_t fmt_q;
    logic   take;

    assign take = lcr_wr && (wdata != DATA_W'(LCR_EXT_KEY));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    fmt_q <= '0;
        else if (take) fmt_q <= frame_t'(wdata[3:0]);
    end

    assign data_bits = 4'(MIN_BITS) + {2'b00, fmt_q.wlen};
    assign stop_two  = fmt_q.stop_two;
    assign parity_en = fmt_q.parity_en;

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_regbank_pkg::*;
#(
    parameter int          ADDR_W      = 4,
    parameter int          DATA_W      = 8,
    parameter int          MODE_W      = 3,
    parameter int          ENH_BIT     = 4,
    parameter logic [2:0]  MODE_HOLD   = 3'd7,
    parameter logic [2:0]  MODE_UART   = 3'd0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic [DATA_W-1:0]   iir_in,
    output logic [2*DATA_W-1:0] divisor,
    output logic [3:0]          data_bits,
    output logic                stop_two,
    output logic                parity_en,
    output logic                fifo_en,
    output logic                rx_fifo_clr,
    output logic                tx_fifo_clr,
    output logic                enh_en,
    output logic [MODE_W-1:0]   op_mode,
    output logic                uart_enable
);

    localparam logic [ADDR_W-1:0] OFF_DLO  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_DHI  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFF_FIFO = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] OFF_LCR  = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] OFF_MODE = ADDR_W'(8);

    logic [DATA_W-1:0] lcr_q, dlo_q, dhi_q, efr_q;
    logic [MODE_W-1:0] mode_q;
    view_e             view;
    logic              sel_div, sel_ext;

    logic wr_lcr, wr_dlo, wr_dhi, wr_efr, wr_fcr, wr_mode;

    assign wr_lcr  = wr_en && (addr == OFF_LCR);
    assign wr_dlo  = wr_en && (addr == OFF_DLO)  && sel_div;
    assign wr_dhi  = wr_en && (addr == OFF_DHI)  && sel_div;
    assign wr_efr  = wr_en && (addr == OFF_FIFO) && sel_ext;
    assign wr_fcr  = wr_en && (addr == OFF_FIFO) && !sel_ext;
    assign wr_mode = wr_en && (addr == OFF_MODE);

    uart_view_fsm #(.DATA_W(DATA_W)) u_view (
        .clk     (clk),
        .rst_n   (rst_n),
        .lcr_wr  (wr_lcr),
        .wdata   (wdata),
        .view    (view),
        .sel_div (sel_div),
        .sel_ext (sel_ext)
    );

    uart_fifo_ctl #(.DATA_W(DATA_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .fcr_wr  (wr_fcr),
        .wdata   (wdata),
        .fifo_en (fifo_en),
        .rx_clr  (rx_fifo_clr),
        .tx_clr  (tx_fifo_clr)
    );

    uart_fmt_decode #(.DATA_W(DATA_W)) u_fmt (
        .clk       (clk),
        .rst_n     (rst_n),
        .lcr_wr    (wr_lcr),
        .wdata     (wdata),
        .data_bits (data_bits),
        .stop_two  (stop_two),
        .parity_en (parity_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcr_q  <= '0;
            dlo_q  <= '0;
            dhi_q  <= '0;
            efr_q  <= '0;
            mode_q <= MODE_W'(MODE_HOLD);
        end else begin
            if (wr_lcr)  lcr_q  <= wdata;
            if (wr_dlo)  dlo_q  <= wdata;
            if (wr_dhi)  dhi_q  <= wdata;
            if (wr_efr)  efr_q  <= wdata;
            if (wr_mode) mode_q <= wdata[MODE_W-1:0];
        end
    end

    // Read-back path, selected by the view state
    always_comb begin
        rdata = '0;
        unique case (view)
            VIEW_NORMAL: begin
                if (addr == OFF_FIFO) rdata = iir_in;
            end
            VIEW_DIVISOR: begin
                if (addr == OFF_DLO)       rdata = dlo_q;
                else if (addr == OFF_DHI)  rdata = dhi_q;
                else if (addr == OFF_FIFO) rdata = iir_in;
            end
            VIEW_EXTENDED: begin
                if (addr == OFF_DLO)       rdata = dlo_q;
                else if (addr == OFF_DHI)  rdata = dhi_q;
                else if (addr == OFF_FIFO) rdata = efr_q;
            end
            default: rdata = '0;
        endcase
        if (addr == OFF_LCR)  rdata = lcr_q;
        if (addr == OFF_MODE) rdata = DATA_W'(mode_q);
    end

    assign divisor     = {dhi_q, dlo_q};
    assign enh_en      = efr_q[ENH_BIT];
    assign op_mode     = mode_q;
    assign uart_enable = (mode_q == MODE_W'(MODE_UART));

endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk
    import uart_regbank_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int MODE_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W-1:0]   lcr_q,
    input  view_e               view,
    input  logic [2*DATA_W-1:0] divisor,
    input  logic [3:0]          data_bits,
    input  logic                stop_two,
    input  logic                parity_en,
    input  logic                rx_fifo_clr,
    input  logic                tx_fifo_clr,
    input  logic                enh_en,
    input  logic [MODE_W-1:0]   op_mode
);

    // R4: the extended view is active exactly when line control holds the key
    assert_ext_view_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (view == VIEW_EXTENDED) == (lcr_q == DATA_W'(LCR_EXT_KEY)));

    // R3: the divisor changes only via offset 0/1 writes with bank bit set
    assert_div_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(divisor) |-> $past(wr_en && (addr == ADDR_W'(0) || addr == ADDR_W'(1)) && lcr_q[7]));

    // R5: enhanced flag changes only on an offset-2 write under the key
    assert_efr_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(enh_en) |-> $past(wr_en && addr == ADDR_W'(2) && lcr_q == DATA_W'(LCR_EXT_KEY)));

    // R7: receive clear strobe only follows a FIFO-control write with bit 1
    assert_rxclr_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fifo_clr |-> $past(wr_en && addr == ADDR_W'(2) && wdata[1] && lcr_q != DATA_W'(LCR_EXT_KEY)));

    // R7: transmit clear strobe only follows a FIFO-control write with bit 2
    assert_txclr_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fifo_clr |-> $past(wr_en && addr == ADDR_W'(2) && wdata[2] && lcr_q != DATA_W'(LCR_EXT_KEY)));

    // R9: writing the key leaves the frame format untouched
    assert_fmt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && addr == ADDR_W'(3) && wdata == DATA_W'(LCR_EXT_KEY))
        |-> $stable({data_bits, stop_two, parity_en}));

    // R10: operating mode changes only by a write to offset 8
    assert_mode_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(op_mode) |-> $past(wr_en && addr == ADDR_W'(8)));

endmodule

bind uart_regbank uart_regbank_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .MODE_W (MODE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .wr_en       (wr_en),
    .wdata       (wdata),
    .lcr_q       (lcr_q),
    .view        (view),
    .divisor     (divisor),
    .data_bits   (data_bits),
    .stop_two    (stop_two),
    .parity_en   (parity_en),
    .rx_fifo_clr (rx_fifo_clr),
    .tx_fifo_clr (tx_fifo_clr),
    .enh_en      (enh_en),
    .op_mode     (op_mode)
);

// File: tb/uart_regbank_tb.sv
module uart_regbank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [7:0]  iir_in = 8'hC1;
    logic [15:0] divisor;
    logic [3:0]  data_bits;
    logic        stop_two, parity_en, fifo_en, rx_fifo_clr, tx_fifo_clr, enh_en;
    logic [2:0]  op_mode;
    logic        uart_enable;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .iir_in(iir_in), .divisor(divisor), .data_bits(data_bits),
        .stop_two(stop_two), .parity_en(parity_en), .fifo_en(fifo_en),
        .rx_fifo_clr(rx_fifo_clr), .tx_fifo_clr(tx_fifo_clr), .enh_en(enh_en),
        .op_mode(op_mode), .uart_enable(uart_enable)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Write completes on the posedge inside; returns at the next negedge
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; wr_en = 1'b0;
        #1 d = rdata;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 divisor", divisor, 16'h0000);
        chk("R1 enh_en", enh_en, 0);
        chk("R1 op_mode", op_mode, 7);
        chk("R1 uart_enable", uart_enable, 0);
        chk("R1 fifo_en", fifo_en, 0);
        chk("R1 clr strobes", {rx_fifo_clr, tx_fifo_clr}, 0);
        chk("R1 format", {data_bits, stop_two, parity_en}, {4'd5, 2'b00});
        rd(4'd3, d); chk("R1 lcr read", d, 8'h00);
        rd(4'd8, d); chk("R1 mode read", d, 8'h07);
    endtask

    task automatic t_lcr_format();
        logic [7:0] d;
        wr(4'd3, 8'h1B); rd(4'd3, d); chk("R2 lcr readback", d, 8'h1B);
        chk("R8 fmt 0x1B", {data_bits, stop_two, parity_en}, {4'd8, 2'b01});
        wr(4'd3, 8'h07);
        chk("R8 fmt 0x07", {data_bits, stop_two, parity_en}, {4'd8, 2'b10});
        wr(4'd3, 8'h01);
        chk("R8 fmt 0x01", {data_bits, stop_two, parity_en}, {4'd6, 2'b00});
    endtask

    task automatic t_divisor();
        logic [7:0] d;
        wr(4'd3, 8'h80);
        wr(4'd0, 8'd42); wr(4'd1, 8'd0);
        chk("R3 divisor 42", divisor, 16'h002A);
        rd(4'd0, d); chk("R3 low read", d, 8'h2A);
        wr(4'd3, 8'h83); wr(4'd1, 8'h12);
        chk("R3 high byte", divisor, 16'h122A);
        rd(4'd1, d); chk("R3 high read", d, 8'h12);
        wr(4'd3, 8'h03);
        rd(4'd0, d); chk("R6 normal off0 read", d, 8'h00);
        rd(4'd1, d); chk("R6 normal off1 read", d, 8'h00);
        wr(4'd0, 8'h55); wr(4'd1, 8'h66);
        chk("R6 normal writes ignored", divisor, 16'h122A);
    endtask

    task automatic t_fifo_ctl();
        logic [7:0] d;
        wr(4'd3, 8'h03);
        wr(4'd2, 8'h07);
        chk("R7 strobes after 0x07", {fifo_en, rx_fifo_clr, tx_fifo_clr}, 3'b111);
        @(negedge clk);
        chk("R7 strobes self-clear", {fifo_en, rx_fifo_clr, tx_fifo_clr}, 3'b100);
        rd(4'd2, d); chk("R6 off2 reads iir", d, 8'hC1);
        iir_in = 8'h04;
        rd(4'd2, d); chk("R6 off2 follows iir", d, 8'h04);
        wr(4'd2, 8'h02);
        chk("R7 rx only", {fifo_en, rx_fifo_clr, tx_fifo_clr}, 3'b010);
        wr(4'd3, 8'h80);
        wr(4'd2, 8'h05);
        chk("R6 fcr in divisor view", {fifo_en, rx_fifo_clr, tx_fifo_clr}, 3'b101);
        rd(4'd2, d); chk("R6 divisor view iir", d, 8'h04);
    endtask

    task automatic t_extended();
        logic [7:0] d;
        logic       fe;
        wr(4'd3, 8'h03);
        wr(4'd3, 8'hBF);
        chk("R9 fmt held", {data_bits, stop_two, parity_en}, {4'd8, 2'b00});
        rd(4'd3, d); chk("R2 lcr BF", d, 8'hBF);
        fe = fifo_en;
        wr(4'd2, 8'h16);
        chk("R4 enh_en set", enh_en, 1);
        chk("R4 no fcr strobes", {rx_fifo_clr, tx_fifo_clr}, 2'b00);
        chk("R4 fifo_en kept", fifo_en, fe);
        rd(4'd2, d); chk("R4 efr read", d, 8'h16);
        wr(4'd0, 8'd42); wr(4'd1, 8'd0);
        chk("R3 divisor in ext view", divisor, 16'h002A);
        wr(4'd3, 8'h03);
        rd(4'd2, d); chk("R6 iir after exit", d, 8'h04);
    endtask

    task automatic t_efr_guard();
        wr(4'd3, 8'h03); wr(4'd2, 8'h00);
        chk("R5 normal write keeps efr", enh_en, 1);
        wr(4'd3, 8'h80); wr(4'd2, 8'h00);
        chk("R5 divisor write keeps efr", enh_en, 1);
        wr(4'd3, 8'hBF); wr(4'd2, 8'h00);
        chk("R4 efr cleared under key", enh_en, 0);
        wr(4'd3, 8'h03);
    endtask

    task automatic t_mode();
        logic [7:0] d;
        wr(4'd8, 8'h00);
        chk("R10 plain uart", {op_mode, uart_enable}, 4'b0001);
        rd(4'd8, d); chk("R10 mode read", d, 8'h00);
        wr(4'd8, 8'h07);
        chk("R10 held", {op_mode, uart_enable}, 4'b1110);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        wr(4'd5, 8'hFF); wr(4'd9, 8'hFF);
        rd(4'd5, d); chk("R11 off5 read", d, 8'h00);
        rd(4'd9, d); chk("R11 off9 read", d, 8'h00);
        rd(4'd3, d); chk("R11 lcr untouched", d, 8'h03);
        chk("R11 mode untouched", op_mode, 7);
    endtask

    task automatic t_boot_sequence();
        logic [7:0] d;
        wr(4'd8, 8'h07);
        wr(4'd3, 8'hBF);
        rd(4'd2, d); wr(4'd2, d | 8'h10);
        wr(4'd3, 8'h80);
        wr(4'd2, 8'h07);
        wr(4'd3, 8'hBF);
        wr(4'd0, 8'd42); wr(4'd1, 8'd0);
        wr(4'd3, 8'h03);
        wr(4'd8, 8'h00);
        chk("R3 boot divisor", divisor, 16'd42);
        chk("R4 boot enh_en", enh_en, 1);
        chk("R8 boot 8N1", {data_bits, stop_two, parity_en}, {4'd8, 2'b00});
        chk("R10 boot mode", {op_mode, uart_enable}, 4'b0001);
        chk("R7 boot fifo_en", fifo_en, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lcr_format();
        t_divisor();
        t_fifo_ctl();
        t_extended();
        t_efr_guard();
        t_mode();
        t_unmapped();
        t_boot_sequence();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog all-requirements actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule